// File: doc/BRIEF.md
# Synchronized Programmable Divider Pair

This block holds the two programmable counters that feed a phase comparator in a frequency synthesizer. The main counter runs on a clock derived from the oscillator under control and the reference counter runs on a crystal-derived clock. Each counter divides its clock by a programmed ratio and emits a one-cycle pulse once per period. Each pulse marks the edge that the comparator uses.

Ratio words arrive from the programming side with a load strobe in the domain of the counter that uses them. A loaded word waits in a holding register. The counter takes it only at its terminal count, or at once while the counter is stopped, so a period in progress is never cut short or stretched. Values below the legal minimum are raised to that minimum.

Power control combines a pin-level enable and a software enable bit. A polarity pin chooses whether both are active high or active low. The combined enable is resynchronized into each clock domain. While it is off, both counters are held at their start value and stay silent. When it turns on, both counters restart from a full period on their next edges, so the first comparator edges carry no leftover phase. The active flag reports the enable as seen in the reference domain.

Top module: `divpair_top`

## Requirements
- R1: While `rst_n` is low and after its release with the block disabled, `active` is 0 and neither `main_pulse` nor `ref_pulse` pulses; after reset both counters hold a ratio equal to their minimum.
- R2: With the block active, `main_pulse` is high for exactly one `clk_main` cycle every N cycles, where N is the accepted main ratio (17-bit word, legal range 512 to 131071).
- R3: With the block active, `ref_pulse` is high for exactly one `clk_ref` cycle every M cycles, where M is the accepted reference ratio (11-bit word, legal range 8 to 2047).
- R4: A ratio word below its minimum is accepted as the minimum: main words below 512 give a period of 512, and reference words below 8 give a period of 8.
- R5: The combined enable is true only when both `pon` and `spon` equal `pol` (`pol`=1: both active high; `pol`=0: both active low). `active` follows it two `clk_ref` edges later.
- R6: While `active` is 0, no `ref_pulse` occurs from the cycle after `active` is seen low, and no `main_pulse` occurs once the main domain has seen the enable drop.
- R7: A word loaded during a period does not change that period. The period completes with the old ratio and the next period uses the new one. If several loads arrive before a boundary, the last one wins.
- R8: On power-up each counter restarts from a full period. The first `ref_pulse` comes exactly M `clk_ref` edges after `active` rises. The first `main_pulse` comes N+2 `clk_main` edges after the enable changes, counting the two synchronizer edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| clk_main | input | 1 | Oscillator-derived clock for the main counter |
| clk_ref | input | 1 | Crystal-derived clock for the reference counter |
| main_word | input | 17 | Main divide ratio word |
| main_load | input | 1 | Strobe (clk_main domain) that captures `main_word` into the holding register |
| ref_word | input | 11 | Reference divide ratio word |
| ref_load | input | 1 | Strobe (clk_ref domain) that captures `ref_word` into the holding register |
| pon | input | 1 | Pin-level power enable |
| pol | input | 1 | Enable polarity: 1 active high, 0 active low |
| spon | input | 1 | Software power enable bit |
| main_pulse | output | 1 | One-cycle main divider edge pulse |
| ref_pulse | output | 1 | One-cycle reference divider edge pulse |
| active | output | 1 | Combined enable, synchronized to clk_ref |

## Verification
The counters are run at several ratios in the interior of the range and at both minimums. Words below the minimum are also applied, which separates clamping from plain truncation or wrap. One load lands in the middle of a period. The interval that contains it must keep the old length and the following interval must take the new one, which separates boundary-only updates from an immediate reload. The enables are swept through all polarity combinations to tell an XNOR-style level match from a plain AND. The power-up latency is counted edge by edge in both domains, which shows whether a counter restarts from a full period or from stale state.

// File: rtl/divpair_pkg.sv
package divpair_pkg;
  localparam int MAIN_W_DEF   = 17;
  localparam int REF_W_DEF    = 11;
  localparam int MAIN_MIN_DEF = 512;
  localparam int REF_MIN_DEF  = 8;
  localparam int SYNC_DEPTH   = 2;
endpackage

// File: rtl/divpair_sync.sv
module divpair_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/divpair_counter.sv
module divpair_counter #(
  parameter int W   = 11,
  parameter int MIN = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic         pulse
);
  localparam logic [W-1:0] MIN_V = W'(MIN);
  localparam logic [W-1:0] ONE_V = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] cur_q, cur_d;
  logic [W-1:0] pend_q, pend_d;
  logic         pend_v_q, pend_v_d;
  logic         pulse_q, pulse_d;
  logic [W-1:0] word_c;
  logic [W-1:0] next_ratio;
  logic         terminal;
  logic         take;

  always_comb begin
    word_c     = (word < MIN_V) ? MIN_V : word;
    next_ratio = pend_v_q ? pend_q : cur_q;
    terminal   = run && (cnt_q == '0);
    take       = !run || terminal;

    cnt_d    = cnt_q;
    cur_d    = cur_q;
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    pulse_d  = terminal;

    if (take) begin
      cur_d    = next_ratio;
      cnt_d    = next_ratio - ONE_V;
      pend_v_d = 1'b0;
    end else begin
      cnt_d = cnt_q - ONE_V;
    end

    if (load) begin
      pend_d   = word_c;
      pend_v_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= MIN_V - ONE_V;
      cur_q    <= MIN_V;
      pend_q   <= MIN_V;
      pend_v_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      cur_q    <= cur_d;
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
      pulse_q  <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/divpair_top.sv
module divpair_top
  import divpair_pkg::*;
#(
  parameter int MAIN_W   = MAIN_W_DEF,
  parameter int REF_W    = REF_W_DEF,
  parameter int MAIN_MIN = MAIN_MIN_DEF,
  parameter int REF_MIN  = REF_MIN_DEF
) (
  input  logic              rst_n,
  input  logic              clk_main,
  input  logic              clk_ref,
  input  logic [MAIN_W-1:0] main_word,
  input  logic              main_load,
  input  logic [REF_W-1:0]  ref_word,
  input  logic              ref_load,
  input  logic              pon,
  input  logic              pol,
  input  logic              spon,
  output logic              main_pulse,
  output logic              ref_pulse,
  output logic              active
);
  logic en_lvl;
  logic rst_main_n;
  logic rst_ref_n;
  logic run_main;
  logic run_ref;

  assign en_lvl = (pon == pol) && (spon == pol);

  divpair_sync #(.STAGES(SYNC_DEPTH)) u_rst_main (
    .clk(clk_main), .rst_n(rst_n), .d(1'b1), .q(rst_main_n));
  divpair_sync #(.STAGES(SYNC_DEPTH)) u_rst_ref (
    .clk(clk_ref), .rst_n(rst_n), .d(1'b1), .q(rst_ref_n));

  divpair_sync #(.STAGES(SYNC_DEPTH)) u_en_main (
    .clk(clk_main), .rst_n(rst_main_n), .d(en_lvl), .q(run_main));
  divpair_sync #(.STAGES(SYNC_DEPTH)) u_en_ref (
    .clk(clk_ref), .rst_n(rst_ref_n), .d(en_lvl), .q(run_ref));

  divpair_counter #(.W(MAIN_W), .MIN(MAIN_MIN)) u_main (
    .clk(clk_main), .rst_n(rst_main_n), .run(run_main),
    .load(main_load), .word(main_word), .pulse(main_pulse));

  divpair_counter #(.W(REF_W), .MIN(REF_MIN)) u_ref (
    .clk(clk_ref), .rst_n(rst_ref_n), .run(run_ref),
    .load(ref_load), .word(ref_word), .pulse(ref_pulse));

  assign active = run_ref;
endmodule

// File: rtl/divpair_chk.sv
module divpair_chk (
  input logic rst_n,
  input logic clk_main,
  input logic clk_ref,
  input logic pon,
  input logic pol,
  input logic spon,
  input logic main_pulse,
  input logic ref_pulse,
  input logic active
);
  logic en_lvl;
  assign en_lvl = (pon == pol) && (spon == pol);

  // R2
  main_single_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
    main_pulse |=> !main_pulse);

  // R3
  ref_single_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  // R6
  ref_quiet_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !active |=> !ref_pulse);

  // R5
  active_rise_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(active) |-> $past(en_lvl, 2));

  // R5
  active_fall_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(active) |-> !$past(en_lvl, 2));

  // R8
  ref_restart_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(active) |-> !ref_pulse);
endmodule

bind divpair_top divpair_chk u_chk (
  .rst_n(rst_n), .clk_main(clk_main), .clk_ref(clk_ref),
  .pon(pon), .pol(pol), .spon(spon),
  .main_pulse(main_pulse), .ref_pulse(ref_pulse), .active(active));

// File: tb/tb_divpair_top.sv
module tb_divpair_top;
  logic        clk_main = 1'b0;
  logic        clk_ref  = 1'b0;
  logic        rst_n;
  logic [16:0] main_word;
  logic        main_load;
  logic [10:0] ref_word;
  logic        ref_load;
  logic        pon, pol, spon;
  logic        main_pulse, ref_pulse, active;

  int checks = 0;
  int fails  = 0;
  int ref_seen = 0;
  int main_seen = 0;
  bit done = 1'b0;

  always #5 clk_ref  = ~clk_ref;
  always #2 clk_main = ~clk_main;

  divpair_top dut (
    .rst_n(rst_n), .clk_main(clk_main), .clk_ref(clk_ref),
    .main_word(main_word), .main_load(main_load),
    .ref_word(ref_word), .ref_load(ref_load),
    .pon(pon), .pol(pol), .spon(spon),
    .main_pulse(main_pulse), .ref_pulse(ref_pulse), .active(active));

  always @(negedge clk_ref)  if (ref_pulse)  ref_seen++;
  always @(negedge clk_main) if (main_pulse) main_seen++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ref_period(output int p);
    int g = 0;
    do begin @(negedge clk_ref); g++; end while (!ref_pulse && g < 5000);
    p = 0;
    do begin @(negedge clk_ref); p++; end while (!ref_pulse && p < 5000);
  endtask

  task automatic main_period(output int p);
    int g = 0;
    do begin @(negedge clk_main); g++; end while (!main_pulse && g < 5000);
    p = 0;
    do begin @(negedge clk_main); p++; end while (!main_pulse && p < 5000);
  endtask

  task automatic load_ref(input int v);
    @(negedge clk_ref);
    ref_word = 11'(v);
    ref_load = 1'b1;
    @(negedge clk_ref);
    ref_load = 1'b0;
  endtask

  task automatic load_main(input int v);
    @(negedge clk_main);
    main_word = 17'(v);
    main_load = 1'b1;
    @(negedge clk_main);
    main_load = 1'b0;
  endtask

  task automatic t_reset();
    repeat (40) @(negedge clk_ref);
    check("R1 active after reset", int'(active), 0);
    check("R1 ref pulses while off", ref_seen, 0);
    check("R1 main pulses while off", main_seen, 0);
  endtask

  task automatic t_polarity();
    pol = 1'b1; pon = 1'b1; spon = 1'b0;
    repeat (6) @(negedge clk_ref);
    check("R5 pol=1 pon=1 spon=0", int'(active), 0);
    spon = 1'b1;
    repeat (6) @(negedge clk_ref);
    check("R5 pol=1 pon=1 spon=1", int'(active), 1);
    pol = 1'b0; pon = 1'b0; spon = 1'b0;
    repeat (6) @(negedge clk_ref);
    check("R5 pol=0 pon=0 spon=0", int'(active), 1);
    pon = 1'b1;
    repeat (6) @(negedge clk_ref);
    check("R5 pol=0 pon=1 spon=0", int'(active), 0);
    pol = 1'b1; pon = 1'b1; spon = 1'b1;
    repeat (6) @(negedge clk_ref);
    check("R5 restore on", int'(active), 1);
  endtask

  task automatic t_ref_period();
    int p;
    ref_period(p);
    check("R3 ref default period", p, 8);
    load_ref(20);
    ref_period(p);
    ref_period(p);
    check("R3 ref period 20", p, 20);
    ref_period(p);
    check("R3 ref period 20 repeat", p, 20);
  endtask

  task automatic t_main_period();
    int p;
    main_period(p);
    check("R2 main default period", p, 512);
    load_main(600);
    main_period(p);
    main_period(p);
    check("R2 main period 600", p, 600);
    main_period(p);
    check("R2 main period 600 repeat", p, 600);
  endtask

  task automatic t_clamp();
    int p;
    load_ref(3);
    ref_period(p);
    ref_period(p);
    check("R4 ref word 3 clamped", p, 8);
    load_main(100);
    main_period(p);
    main_period(p);
    check("R4 main word 100 clamped", p, 512);
  endtask

  task automatic t_boundary();
    int p;
    int q;
    load_ref(40);
    ref_period(p);
    ref_period(p);
    check("R7 ref period 40 before change", p, 40);
    p = 0;
    do begin @(negedge clk_ref); end while (!ref_pulse);
    do begin
      @(negedge clk_ref);
      p++;
      if (p == 5) begin ref_word = 11'd30; ref_load = 1'b1; end
      if (p == 6) begin ref_word = 11'd12; ref_load = 1'b1; end
      if (p == 7) ref_load = 1'b0;
    end while (!ref_pulse && p < 5000);
    check("R7 period holding the loads keeps old ratio", p, 40);
    q = 0;
    do begin @(negedge clk_ref); q++; end while (!ref_pulse && q < 5000);
    check("R7 next period uses last loaded ratio", q, 12);
  endtask

  task automatic t_powerdown();
    int r0;
    int m0;
    spon = 1'b0;
    repeat (10) @(negedge clk_ref);
    check("R6 active low after spon drop", int'(active), 0);
    r0 = ref_seen;
    m0 = main_seen;
    repeat (300) @(negedge clk_ref);
    check("R6 no ref pulses while down", ref_seen - r0, 0);
    check("R6 no main pulses while down", main_seen - m0, 0);
  endtask

  task automatic t_powerup();
    int n;
    int q;
    @(negedge clk_main);
    spon = 1'b1;
    fork
      begin
        n = 0;
        do begin @(negedge clk_main); n++; end while (!main_pulse && n < 5000);
      end
      begin
        while (!active) @(negedge clk_ref);
        q = 0;
        do begin @(negedge clk_ref); q++; end while (!ref_pulse && q < 5000);
      end
    join
    check("R8 first main pulse after enable", n, 514);
    check("R8 first ref pulse after active", q, 12);
  endtask

  initial begin
    rst_n = 1'b0;
    pon = 1'b0; pol = 1'b1; spon = 1'b0;
    main_word = '0; main_load = 1'b0;
    ref_word = '0; ref_load = 1'b0;
    check("R1 active in reset", int'(active), 0);
    #53;
    rst_n = 1'b1;
    t_reset();
    t_polarity();
    t_ref_period();
    t_main_period();
    t_clamp();
    t_boundary();
    t_powerdown();
    t_powerup();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule